// File: doc/BRIEF.md
# PWM Time-Base Counter with Prescaler

This block produces the shared timing reference for a two-output pulse-width modulator. A counter of `CNT_W` bits (16 by default) advances once per prescaled tick and follows one of four counting modes. The tick rate comes from two cascaded divider factors. A period register sets the counter's turning point. Compare and action logic further down the chip read the counter value, a zero event, a period event and a direction flag.

Software drives the block through a 16-bit register port. Address 0 holds a control word that sets the counting mode, the two divider fields and the period-load policy. Address 1 accepts period writes. The port can also read back the active period, the pending (shadow) period and the live counter. A period write either waits in the shadow copy until the counter next passes zero, or takes effect at once.

Top module: `pwm_timebase`

## Requirements
- R1: Address map on `addr_i`: 0 is control (read and write), 1 is period (write; a read returns the active period), 2 returns the shadow period, and 3 returns the counter. Writes to addresses 2 and 3 change nothing. Control readback keeps bits [12:7], [3] and [1:0] and returns 0 in all other bits. Read data is combinational from `addr_i`.
- R2: Control bits [1:0] select the counting mode: 00 up, 01 down, 10 up-down, 11 freeze.
- R3: Let c be control bits [12:10] and h be control bits [9:7]. The prescale factor is N = 2^c × (h == 0 ? 1 : 2h). A tick occurs when the prescale count equals N−1, so the counter advances once every N clocks. A control write restarts the prescale count at 0.
- R4: In up mode, on a tick, the counter goes to 0 when it is at or above the active period; otherwise it increments.
- R5: In down mode, on a tick, the counter loads the active period when it is 0; otherwise it decrements.
- R6: In up-down mode, a tick while rising at or above the period turns the direction to falling and steps down, never below 0. A tick while falling at 0 turns the direction to rising and steps to 1, or stays at 0 if the period is 0. A control write sets the direction to rising. `dir_up_o` is 1 in up mode, 0 in down mode, and shows the tracked direction in the other two modes.
- R7: `zero_o` is high for exactly the cycles that have a tick, a non-freeze mode and a counter of 0. `prd_o` is high for exactly the cycles that have a tick, a non-freeze mode and a counter equal to the active period.
- R8: In freeze mode the counter holds its value, and neither event is raised.
- R9: When control bit 3 is 0, a period write updates only the shadow copy, and the shadow copies into the active period on each zero event. When bit 3 is 1, a period write updates both copies at once. If a zero-event load and a period write fall on the same cycle, the write wins.
- R10: Reset sets the control word to 0x0003 (freeze, both dividers 0, shadow loading), clears the counter, both period copies and the prescale count, and sets the direction to rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| cnt_o | output | CNT_W | Counter value |
| zero_o | output | 1 | Counter-equals-zero event |
| prd_o | output | 1 | Counter-equals-period event |
| dir_up_o | output | 1 | Counting direction, 1 = rising |

## Verification
The assertions take the control word's mode bits as they are and assume a mode is held for at least one tick before its counting rules apply. The up-step property is written only for cycles where up mode was already set on the previous cycle. The stimulus changes mode only through whole control writes, always held for one clock. After each write it runs long enough for several prescaled ticks, so every mode-transition cycle the checker sees comes from a clean single-cycle write.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  typedef enum logic [1:0] {
    MODE_UP   = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UPDN = 2'b10,
    MODE_HOLD = 2'b11
  } cnt_mode_e;

  localparam int REG_W     = 16;
  localparam int DIV_W     = 3;
  localparam int CDIV_LSB  = 10;
  localparam int HDIV_LSB  = 7;
  localparam int IMM_BIT   = 3;
  localparam logic [REG_W-1:0] CTRL_MASK  = 16'h1F8B;
  localparam logic [REG_W-1:0] CTRL_RESET = 16'h0003;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PRD  = 2'd1;
  localparam logic [1:0] ADDR_SHD  = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  // largest factor: 2^(2^DIV_W-1) * 2*(2^DIV_W-1)
  localparam int DIV_MAX = 2**DIV_W - 1;
  localparam int PRE_W   = DIV_MAX + $clog2(2*DIV_MAX) + 1;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] cdiv_i,
  input  logic [DIV_W-1:0] hdiv_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] hs_fac;
  logic [PRE_W-1:0] n_m1;

  always_comb begin
    hs_fac = (hdiv_i == '0) ? PRE_W'(1) : PRE_W'({hdiv_i, 1'b0});
    n_m1   = (hs_fac << cdiv_i) - PRE_W'(1);
  end

  assign tick_o = (pre_q == n_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/pwm_period.sv
module pwm_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             imm_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] active_o,
  output logic [CNT_W-1:0] shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= '0;
      shadow_o <= '0;
    end else begin
      if (wr_i) shadow_o <= wdata_i;
      // a direct write overrides a same-cycle zero load
      if (wr_i && imm_i)  active_o <= wdata_i;
      else if (load_i)    active_o <= shadow_o;
    end
  end
endmodule

// File: rtl/pwm_count.sv
module pwm_count
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic             zero_o,
  output logic             prd_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dir_q, dir_d;
  logic [CNT_W-1:0] cnt_d;
  logic             run;

  assign run    = tick_i && (mode_i != MODE_HOLD);
  assign zero_o = run && (cnt_o == '0);
  assign prd_o  = run && (cnt_o == prd_i);

  always_comb begin
    cnt_d = cnt_o;
    dir_d = dir_q;
    if (run) begin
      unique case (mode_i)
        MODE_UP:   cnt_d = (cnt_o >= prd_i) ? '0 : cnt_o + ONE;
        MODE_DOWN: cnt_d = (cnt_o == '0) ? prd_i : cnt_o - ONE;
        MODE_UPDN: begin
          if (dir_q) begin
            if (cnt_o >= prd_i) begin
              dir_d = 1'b0;
              cnt_d = (cnt_o != '0) ? cnt_o - ONE : '0;
            end else begin
              cnt_d = cnt_o + ONE;
            end
          end else begin
            if (cnt_o == '0) begin
              dir_d = 1'b1;
              cnt_d = (prd_i != '0) ? ONE : '0;
            end else begin
              cnt_d = cnt_o - ONE;
            end
          end
        end
        default: cnt_d = cnt_o;
      endcase
    end
    if (restart_i) dir_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_o <= cnt_d;
      dir_q <= dir_d;
    end
  end

  always_comb begin
    unique case (mode_i)
      MODE_UP:   dir_up_o = 1'b1;
      MODE_DOWN: dir_up_o = 1'b0;
      default:   dir_up_o = dir_q;
    endcase
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             prd_o,
  output logic             dir_up_o
);
  logic [REG_W-1:0] ctrl_q;
  logic             ctrl_wr, prd_wr, tick;
  cnt_mode_e        mode;
  logic [CNT_W-1:0] prd_act, prd_shd;

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_CTRL);
  assign prd_wr  = wr_en_i && (addr_i == ADDR_PRD);
  assign mode    = cnt_mode_e'(ctrl_q[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_RESET;
    else if (ctrl_wr) ctrl_q <= wdata_i & CTRL_MASK;
  end

  pwm_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_wr),
    .cdiv_i (ctrl_q[CDIV_LSB +: DIV_W]),
    .hdiv_i (ctrl_q[HDIV_LSB +: DIV_W]),
    .tick_o (tick)
  );

  pwm_period #(.CNT_W(CNT_W)) u_prd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (prd_wr),
    .wdata_i  (wdata_i[CNT_W-1:0]),
    .imm_i    (ctrl_q[IMM_BIT]),
    .load_i   (zero_o),
    .active_o (prd_act),
    .shadow_o (prd_shd)
  );

  pwm_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .mode_i    (mode),
    .prd_i     (prd_act),
    .restart_i (ctrl_wr),
    .cnt_o     (cnt_o),
    .dir_up_o  (dir_up_o),
    .zero_o    (zero_o),
    .prd_o     (prd_o)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_PRD:  rdata_o = REG_W'(prd_act);
      ADDR_SHD:  rdata_o = REG_W'(prd_shd);
      default:   rdata_o = REG_W'(cnt_o);
    endcase
  end
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] prd_i,
  input logic             zero_i,
  input logic             pevt_i
);
  // R8: counter frozen while freeze mode persists
  a_r8_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && $past(mode_i) == 2'b11) |-> $stable(cnt_i));

  // R8: no events in freeze mode
  a_r8_freeze_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> (!zero_i && !pevt_i));

  // R4: up mode wraps after the period event
  a_r4_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && pevt_i) |=> (cnt_i == '0));

  // R4: up mode only steps by one or wraps to zero
  a_r4_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && $past(mode_i) == 2'b00 && !$stable(cnt_i))
      |-> (cnt_i == '0 || cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  // R5: down mode reloads the period after zero
  a_r5_down_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && zero_i) |=> (cnt_i == $past(prd_i)));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode_i (ctrl_q[1:0]),
  .cnt_i  (cnt_o),
  .prd_i  (prd_act),
  .zero_i (zero_o),
  .pevt_i (prd_o)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = 16'd0;
  logic [15:0] rdata_o;
  logic [15:0] cnt_o;
  logic        zero_o, prd_o, dir_up_o;

  always #2.5 clk = ~clk;

  pwm_timebase dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_o(cnt_o), .zero_o(zero_o),
    .prd_o(prd_o), .dir_up_o(dir_up_o)
  );

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  int m_ctrl, m_pre, m_cnt, m_act, m_shd;
  bit m_dir;

  function automatic int mode_f();  return m_ctrl & 3;            endfunction
  function automatic int nfac();
    int c, h;
    c = (m_ctrl >> 10) & 7;
    h = (m_ctrl >> 7) & 7;
    return (1 << c) * ((h == 0) ? 1 : 2 * h);
  endfunction
  function automatic bit tick_f(); return m_pre == nfac() - 1;    endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit run;
    int exp_rd;
    string creq;
    run = tick_f() && mode_f() != 3;
    case (mode_f())
      0: creq = "R4"; 1: creq = "R5"; 2: creq = "R6"; default: creq = "R8";
    endcase
    chk(creq, cnt_o, m_cnt);
    chk("R7", zero_o, run && m_cnt == 0);
    chk("R7", prd_o, run && m_cnt == m_act);
    chk("R6", dir_up_o, mode_f() == 0 ? 1 : mode_f() == 1 ? 0 : m_dir);
    case (addr_i)
      0: exp_rd = m_ctrl; 1: exp_rd = m_act; 2: exp_rd = m_shd; default: exp_rd = m_cnt;
    endcase
    chk((addr_i == 1 || addr_i == 2) ? "R9" : "R1", rdata_o, exp_rd);
  endtask

  task automatic model_edge(bit we, int a, int d);
    bit tk, run;
    tk  = tick_f();
    run = tk && mode_f() != 3;
    if (run && m_cnt == 0) m_act = m_shd;           // R9 zero load
    if (run) begin
      case (mode_f())
        0: m_cnt = (m_cnt >= m_act_prev) ? 0 : (m_cnt + 1) & 16'hFFFF;
        1: m_cnt = (m_cnt == 0) ? m_act_prev : m_cnt - 1;
        2: if (m_dir) begin
             if (m_cnt >= m_act_prev) begin m_dir = 0; m_cnt = (m_cnt != 0) ? m_cnt - 1 : 0; end
             else m_cnt = m_cnt + 1;
           end else begin
             if (m_cnt == 0) begin m_dir = 1; m_cnt = (m_act_prev != 0) ? 1 : 0; end
             else m_cnt = m_cnt - 1;
           end
        default: ;
      endcase
    end
    if (we && a == 1) begin
      if ((m_ctrl >> 3) & 1) m_act = d;
      m_shd = d;
    end
    if (we && a == 0) begin
      m_ctrl = d & 16'h1F8B; m_pre = 0; m_dir = 1;
    end else begin
      m_pre = tk ? 0 : m_pre + 1;
    end
  endtask

  int m_act_prev;

  task automatic step(bit we, int a, int d);
    compare();
    wr_en_i = we; addr_i = 2'(a); wdata_i = 16'(d);
    m_act_prev = m_act;
    model_edge(we, a, d);
    @(negedge clk);
  endtask

  task automatic idle(int n, int a);
    for (int i = 0; i < n; i++) step(0, a, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R10: reset values
    m_ctrl = 16'h0003; m_pre = 0; m_cnt = 0; m_act = 0; m_shd = 0; m_dir = 1;
    chk("R10", rdata_o, 16'h0003);
    chk("R10", cnt_o, 0);
    idle(5, 3);
    // R1: writes to read-only addresses ignored
    step(1, 2, 16'h1234); step(1, 3, 16'h5678); idle(2, 2); idle(2, 3);
    step(1, 0, 16'hFFFF); idle(2, 0);                 // R1 readback mask
    // R9 immediate: bit3 set, freeze, period 5
    step(1, 0, 16'h000B); step(1, 1, 5); idle(3, 1);
    // R2/R4: up mode, N=1
    step(1, 0, 16'h0008); idle(20, 3);
    // R3: N=2*2=4
    step(1, 0, 16'h0488); idle(60, 3);
    // R3: N=6
    step(1, 0, 16'h0188); idle(80, 3);
    // R5: down mode
    step(1, 0, 16'h0009); idle(25, 3);
    // R6: up-down mode, then period 0 corner
    step(1, 0, 16'h000A); idle(30, 3);
    step(1, 1, 0); idle(8, 3);
    step(1, 1, 4); idle(20, 3);
    // R4 corner: shrink period below counter in up mode
    step(1, 0, 16'h0008); idle(3, 3); step(1, 1, 1); idle(10, 3);
    // R9 shadow: bit3 clear, new period waits for a zero event
    step(1, 1, 6); step(1, 0, 16'h0000); step(1, 1, 3); idle(4, 1); idle(4, 2); idle(30, 1);
    // R9 collision: shadow write lands around zero events
    for (int i = 0; i < 12; i++) step(1, 1, 2 + (i % 3));
    idle(10, 1);
    // R8: freeze holds counter mid-count
    step(1, 0, 16'h0000); idle(2, 3); step(1, 0, 16'h0003); idle(15, 3);
    // R3: largest factor, 2^7*14
    step(1, 0, 16'h1F88); step(1, 1, 2); idle(4000, 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule